// File: doc/BRIEF.md
# Multi-Core Reset and Boot-Release Controller

This block is the memory-mapped reset and start-up controller for a four-core processor cluster. Software reaches it through a word-wide register bus inside a 4 KB window. The registers are a control word, boot-mode words, a reset-status word, interrupt status and mask words, and ten general-purpose words. The block does not sample pins, run boot code or raise interrupts. The status and mode words are plain storage.

All action comes from the control word. Each write to it is compared bit by bit with the stored value, and only bits that flip take effect. A flipped per-core reset bit sends a one-cycle reset pulse to that core. The bit then stays set until the core answers on its acknowledge input. A flipped enable bit powers a secondary core up or down. On power-up it hands the core an entry address and an argument, taken from a pair of general-purpose words fixed for that core. Two peripheral soft-reset bits give a one-cycle strobe and are never stored.

Top module: `mcrst_top`

## Requirements
- R1: After reset the control word (index 0) reads 0x0000_0521, the reset-status word (index 2) reads 0x1, the interrupt-mask word (index 6) reads 0x1F, every other word reads zero, core_en is 0, and no pulse or strobe is active.
- R2: The word index is byte-offset bits [11:2]. Indices 1 to 17 (boot-mode 1, reset-status, 3, 4, interrupt-status 5, interrupt-mask 6, boot-mode 2 at 7, general-purpose words 1 to 10 at indices 8 to 17) store written data with no side effect. A read returns data combinationally in the same cycle.
- R3: A read of index 18 or above returns zero. A write to such an index changes no register.
- R4: Control-word actions come from stored XOR written. Writing back the stored value produces no pulse, strobe or enable change.
- R5: A flip of control bit 13+k (k = 0..3) stores the written value. It drives core_rst_pulse[k] high for exactly the one cycle after the write edge.
- R6: A core reset bit that is pending stays set until core_ack[k] is seen. It reads as cleared from the cycle after that acknowledge. An acknowledge with nothing pending is ignored.
- R7: Control bit 21+k (k = 1..3) drives core_en[k]. A 0-to-1 flip latches general-purpose words 2k+1 and 2k+2 (indices 8+2k and 9+2k) onto that core's core_entry and core_arg slices (bits [32(k-1)+31 : 32(k-1)]). Later changes to those words do not alter the latched values.
- R8: When a core's enable bit flips, no reset pulse is sent to that core in the same write, even if its reset bit also flips. The core's reset bit still becomes pending and clears on its acknowledge.
- R9: A write to the control word with bit 3 or bit 12 set pulses periph_srst[0] or periph_srst[1] for one cycle. Those bits always read back as zero.
- R10: A new flip for a core whose reset bit is still pending pulses again. An acknowledge arriving in the same cycle as that new flip is overruled, so the bit keeps its written value until the next acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Byte offset bits [11:2] (word index) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| core_ack | input | 4 | Per-core completion acknowledge |
| core_rst_pulse | output | 4 | Per-core one-cycle reset request |
| core_en | output | 3 | Power enable, cores 3 down to 1 |
| core_entry | output | 96 | Latched entry address, 32 bits per core 1..3 |
| core_arg | output | 96 | Latched start argument, 32 bits per core 1..3 |
| periph_srst | output | 2 | One-cycle peripheral soft-reset strobes |

## Verification
A wrong change mask shows up in the cycle right after the write. Either a pulse appears on a rewrite of the same value, or an expected pulse is missing. A wrong pending flag only shows later: a reset bit reads back cleared before any acknowledge, or stays set after one. So the bench reads the control word after every acknowledge. Entry capture faults hide until a general-purpose word is rewritten after power-up, so the bench rewrites those words and checks the latched values again.

// File: rtl/mcrst_pkg.sv
package mcrst_pkg;
  localparam int unsigned NUM_REGS   = 18;
  localparam int unsigned IX_CTRL    = 0;
  localparam int unsigned IX_RSTAT   = 2;
  localparam int unsigned IX_IMASK   = 6;
  localparam int unsigned IX_GPR1    = 8;
  localparam logic [31:0] CTRL_INIT  = 32'h0000_0521;
  localparam logic [31:0] RSTAT_INIT = 32'h0000_0001;
  localparam logic [31:0] IMASK_INIT = 32'h0000_001F;
  localparam int unsigned B_CORE_RST = 13;  // core k reset at 13+k
  localparam int unsigned B_CORE_EN  = 21;  // core k enable at 21+k, k>=1
  localparam int unsigned B_PSRST0   = 3;
  localparam int unsigned B_PSRST1   = 12;

  function automatic logic [31:0] init_value(int unsigned idx);
    if (idx == IX_RSTAT)      return RSTAT_INIT;
    else if (idx == IX_IMASK) return IMASK_INIT;
    else                      return 32'h0;
  endfunction
endpackage

// File: rtl/mcrst_regbank.sv
module mcrst_regbank
  import mcrst_pkg::*;
#(
  parameter int unsigned NREG = NUM_REGS,
  parameter int unsigned IW   = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [IW-1:0]              wr_idx,
  input  logic [31:0]                wdata,
  output logic [NREG-1:0][31:0]      words
);
  assign words[0] = 32'h0;  // control word lives in the control unit

  for (genvar i = 1; i < NREG; i++) begin : g_word
    logic        we;
    logic [31:0] word_q;
    assign we = wr_en && (wr_idx == IW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  word_q <= init_value(i);
      else if (we) word_q <= wdata;
    end
    assign words[i] = word_q;
  end
endmodule

// File: rtl/mcrst_ctl_unit.sv
module mcrst_ctl_unit
  import mcrst_pkg::*;
#(
  parameter int unsigned NCORE = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_ctrl,
  input  logic [31:0]      wdata,
  input  logic [NCORE-1:0] core_ack,
  output logic [31:0]      ctrl_q,
  output logic [NCORE-1:0] en_tog,
  output logic [NCORE-1:0] core_rst_pulse,
  output logic [1:0]       periph_srst
);
  logic [31:0]      chg, ctrl_d;
  logic [NCORE-1:0] rst_req, new_req, pend_q, pend_d, clr_ok;
  logic [1:0]       psr_d;
  logic             ctrl_ce;

  always_comb begin
    chg = ctrl_q ^ wdata;
    for (int k = 0; k < NCORE; k++) begin
      en_tog[k]  = (k != 0) && wr_ctrl && chg[B_CORE_EN + k];
      rst_req[k] = wr_ctrl && chg[B_CORE_RST + k] && !en_tog[k];
    end
    new_req = rst_req | en_tog;
    clr_ok  = pend_q & core_ack & ~new_req;
    ctrl_d  = ctrl_q;
    if (wr_ctrl) begin
      ctrl_d           = wdata;
      ctrl_d[B_PSRST0] = 1'b0;
      ctrl_d[B_PSRST1] = 1'b0;
    end
    for (int k = 0; k < NCORE; k++)
      if (clr_ok[k]) ctrl_d[B_CORE_RST + k] = 1'b0;
    ctrl_ce = wr_ctrl || (|(pend_q & core_ack));
    pend_d  = new_req | (pend_q & ~core_ack);
    psr_d   = {wr_ctrl && wdata[B_PSRST1], wr_ctrl && wdata[B_PSRST0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_q <= CTRL_INIT;
    else if (ctrl_ce) ctrl_q <= ctrl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q         <= '0;
      core_rst_pulse <= '0;
      periph_srst    <= '0;
    end else begin
      pend_q         <= pend_d;
      core_rst_pulse <= rst_req;
      periph_srst    <= psr_d;
    end
  end
endmodule

// File: rtl/mcrst_boot_latch.sv
module mcrst_boot_latch (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        capture,
  input  logic [31:0] entry_in,
  input  logic [31:0] arg_in,
  output logic [31:0] entry_q,
  output logic [31:0] arg_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      entry_q <= '0;
      arg_q   <= '0;
    end else if (capture) begin
      entry_q <= entry_in;
      arg_q   <= arg_in;
    end
  end
endmodule

// File: rtl/mcrst_top.sv
module mcrst_top
  import mcrst_pkg::*;
#(
  parameter int unsigned NCORE = 4,
  parameter int unsigned IW    = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_sel,
  input  logic                     bus_wr,
  input  logic [11:2]              bus_addr,
  input  logic [31:0]              bus_wdata,
  output logic [31:0]              bus_rdata,
  input  logic [NCORE-1:0]         core_ack,
  output logic [NCORE-1:0]         core_rst_pulse,
  output logic [NCORE-1:1]         core_en,
  output logic [(NCORE-1)*32-1:0]  core_entry,
  output logic [(NCORE-1)*32-1:0]  core_arg,
  output logic [1:0]               periph_srst
);
  localparam int unsigned SW = $clog2(NUM_REGS);

  logic [IW-1:0]               idx;
  logic                        in_range, wr_ctrl, wr_plain;
  logic [31:0]                 ctrl_q;
  logic [NCORE-1:0]            en_tog;
  logic [NUM_REGS-1:0][31:0]   words;

  assign idx      = bus_addr;
  assign in_range = (idx < IW'(NUM_REGS));
  assign wr_ctrl  = bus_sel && bus_wr && (idx == IW'(IX_CTRL));
  assign wr_plain = bus_sel && bus_wr && in_range && (idx != IW'(IX_CTRL));

  mcrst_regbank #(.NREG(NUM_REGS), .IW(IW)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_plain), .wr_idx(idx),
    .wdata(bus_wdata), .words(words)
  );

  mcrst_ctl_unit #(.NCORE(NCORE)) u_ctl (
    .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wdata(bus_wdata),
    .core_ack(core_ack), .ctrl_q(ctrl_q), .en_tog(en_tog),
    .core_rst_pulse(core_rst_pulse), .periph_srst(periph_srst)
  );

  for (genvar k = 1; k < NCORE; k++) begin : g_core
    logic cap;
    assign cap        = en_tog[k] && bus_wdata[B_CORE_EN + k];
    assign core_en[k] = ctrl_q[B_CORE_EN + k];
    mcrst_boot_latch u_latch (
      .clk(clk), .rst_n(rst_n), .capture(cap),
      .entry_in(words[IX_GPR1 + 2*k]), .arg_in(words[IX_GPR1 + 2*k + 1]),
      .entry_q(core_entry[(k-1)*32 +: 32]), .arg_q(core_arg[(k-1)*32 +: 32])
    );
  end

  always_comb begin
    bus_rdata = 32'h0;
    if (in_range) begin
      if (idx == IW'(IX_CTRL)) bus_rdata = ctrl_q;
      else                     bus_rdata = words[idx[SW-1:0]];
    end
  end
endmodule

// File: rtl/mcrst_top_chk.sv
module mcrst_top_chk #(
  parameter int unsigned NCORE = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_ctrl,
  input logic             rd_oob,
  input logic             wr_ctrl,
  input logic             wd_p0,
  input logic             wd_p1,
  input logic [31:0]      bus_rdata,
  input logic [31:0]      ctrl_q,
  input logic [NCORE-1:0] core_ack,
  input logic [NCORE-1:0] core_rst_pulse,
  input logic [NCORE-1:1] core_en,
  input logic [1:0]       periph_srst
);
  // R3: out-of-range reads return zero
  a_r3_oob_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_oob |-> bus_rdata == 32'h0);

  // R9: peripheral bits never read back as set
  a_r9_psrst_never_stored: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ctrl |-> (bus_rdata[3] == 1'b0 && bus_rdata[12] == 1'b0));

  // R9: each strobe comes from a control write with its bit set
  a_r9_strobe0_source: assert property (@(posedge clk) disable iff (!rst_n)
    periph_srst[0] |-> $past(wr_ctrl && wd_p0));
  a_r9_strobe1_source: assert property (@(posedge clk) disable iff (!rst_n)
    periph_srst[1] |-> $past(wr_ctrl && wd_p1));

  // R5: a reset pulse follows a control write
  a_r5_pulse_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (|core_rst_pulse) |-> $past(wr_ctrl));

  // R7: enables move only on a control write
  a_r7_enable_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(core_en) |-> $past(wr_ctrl));

  // R6: a reset bit falls only on a write or an acknowledge
  for (genvar k = 0; k < NCORE; k++) begin : g_ack
    a_r6_clear_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ctrl_q[13+k]) |-> $past(wr_ctrl || core_ack[k]));
  end
endmodule

bind mcrst_top mcrst_top_chk #(.NCORE(NCORE)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .rd_ctrl(bus_sel && !bus_wr && idx == '0),
  .rd_oob(bus_sel && !bus_wr && !in_range),
  .wr_ctrl(wr_ctrl), .wd_p0(bus_wdata[3]), .wd_p1(bus_wdata[12]),
  .bus_rdata(bus_rdata), .ctrl_q(ctrl_q), .core_ack(core_ack),
  .core_rst_pulse(core_rst_pulse), .core_en(core_en), .periph_srst(periph_srst)
);

// File: tb/test_mcrst_top.sv
`timescale 1ns/1ps
module test_mcrst_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [11:2] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [3:0]  core_ack, core_rst_pulse;
  logic [3:1]  core_en;
  logic [95:0] core_entry, core_arg;
  logic [1:0]  periph_srst;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] v;

  localparam logic [31:0] C = 32'h0000_0521;
  localparam logic [31:0] RB0 = 32'h1 << 13, RB1 = 32'h1 << 14, RB2 = 32'h1 << 15;
  localparam logic [31:0] EN1 = 32'h1 << 22, EN3 = 32'h1 << 24;

  // {byte offset, write data, expected read}
  localparam logic [75:0] TBL [8] = '{
    {12'h004, 32'h1234_5678, 32'h1234_5678},
    {12'h014, 32'hDEAD_BEEF, 32'hDEAD_BEEF},
    {12'h01C, 32'h0000_00FF, 32'h0000_00FF},
    {12'h020, 32'hCAFE_0001, 32'hCAFE_0001},
    {12'h044, 32'h8765_4321, 32'h8765_4321},
    {12'h048, 32'hFFFF_FFFF, 32'h0000_0000},
    {12'hFFC, 32'h5555_AAAA, 32'h0000_0000},
    {12'h018, 32'h0000_0000, 32'h0000_0000}
  };

  always #2.5 clk = ~clk;

  mcrst_top i_mcrst_top (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .core_ack(core_ack), .core_rst_pulse(core_rst_pulse), .core_en(core_en),
    .core_entry(core_entry), .core_arg(core_arg), .periph_srst(periph_srst)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] ack);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a[11:2]; bus_wdata = d; core_ack = ack;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; core_ack = '0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a[11:2];
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic ack(input logic [3:0] a);
    @(negedge clk); core_ack = a;
    @(negedge clk); core_ack = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got 0x%08h expected 0x%08h", 32'h1, 32'h0);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; bus_sel = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0; core_ack = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(12'h000, v); chk("R1 ctrl", v, C);
    rd(12'h008, v); chk("R1 reset-status", v, 32'h1);
    rd(12'h018, v); chk("R1 irq mask", v, 32'h1F);
    rd(12'h004, v); chk("R1 boot-mode", v, 32'h0);
    rd(12'h040, v); chk("R1 gpr9", v, 32'h0);
    chk("R1 core_en", {29'h0, core_en}, 32'h0);
    chk("R1 pulses", {26'h0, periph_srst, core_rst_pulse}, 32'h0);

    // R2 / R3 table walk
    for (int i = 0; i < 8; i++) begin
      wr(TBL[i][75:64], TBL[i][63:32], 4'h0);
      rd(TBL[i][75:64], v);
      chk((TBL[i][75:64] >= 12'h048) ? "R3 out-of-range" : "R2 storage", v, TBL[i][31:0]);
    end
    rd(12'h000, v); chk("R3 ctrl untouched", v, C);
    rd(12'h008, v); chk("R3 status untouched", v, 32'h1);

    // R5 core 0 reset
    wr(12'h000, C | RB0, 4'h0);
    chk("R5 pulse core0", {28'h0, core_rst_pulse}, 32'h1);
    @(negedge clk);
    chk("R5 pulse one cycle", {28'h0, core_rst_pulse}, 32'h0);
    rd(12'h000, v); chk("R6 bit held", v, C | RB0);

    // R4 same value again
    wr(12'h000, C | RB0, 4'h0);
    chk("R4 no pulse on rewrite", {28'h0, core_rst_pulse}, 32'h0);

    // R6 acknowledges
    ack(4'b0010);
    rd(12'h000, v); chk("R6 stray ack ignored", v, C | RB0);
    ack(4'b0001);
    rd(12'h000, v); chk("R6 ack clears", v, C);

    // R10 re-request while pending, ack overruled
    wr(12'h000, C | RB2, 4'h0);
    chk("R10 first pulse", {28'h0, core_rst_pulse}, 32'h4);
    wr(12'h000, C, 4'h0);
    chk("R10 repulse", {28'h0, core_rst_pulse}, 32'h4);
    wr(12'h000, C | RB2, 4'b0100);
    chk("R10 pulse with ack", {28'h0, core_rst_pulse}, 32'h4);
    rd(12'h000, v); chk("R10 ack overruled", v, C | RB2);
    ack(4'b0100);
    rd(12'h000, v); chk("R10 cleared on next ack", v, C);

    // R7 / R8 core 1 power-up with reset bit flipped too
    wr(12'h028, 32'h1000_0000, 4'h0);
    wr(12'h02C, 32'h0000_A5A5, 4'h0);
    wr(12'h000, C | EN1 | RB1, 4'h0);
    chk("R8 no pulse on enable", {28'h0, core_rst_pulse}, 32'h0);
    chk("R7 core1 enabled", {29'h0, core_en}, 32'h1);
    chk("R7 core1 entry", core_entry[31:0], 32'h1000_0000);
    chk("R7 core1 arg", core_arg[31:0], 32'h0000_A5A5);
    wr(12'h028, 32'h2222_0000, 4'h0);
    chk("R7 entry latched", core_entry[31:0], 32'h1000_0000);
    rd(12'h000, v); chk("R8 bit pending", v, C | EN1 | RB1);
    ack(4'b0010);
    rd(12'h000, v); chk("R8 ack clears", v, C | EN1);

    // R7 core 3 from its own pair, then power-down
    wr(12'h038, 32'h3000_0040, 4'h0);
    wr(12'h03C, 32'h0000_0033, 4'h0);
    wr(12'h000, C | EN1 | EN3, 4'h0);
    chk("R7 core3 enabled", {29'h0, core_en}, 32'h5);
    chk("R7 core3 entry", core_entry[95:64], 32'h3000_0040);
    chk("R7 core3 arg", core_arg[95:64], 32'h0000_0033);
    chk("R7 core1 entry kept", core_entry[31:0], 32'h1000_0000);
    wr(12'h000, C, 4'h0);
    chk("R7 power down", {29'h0, core_en}, 32'h0);
    chk("R8 no pulse on disable", {28'h0, core_rst_pulse}, 32'h0);
    ack(4'b1010);
    rd(12'h000, v); chk("R7 ctrl after down", v, C);

    // R9 peripheral strobes
    wr(12'h000, C | 32'h8, 4'h0);
    chk("R9 strobe 0", {30'h0, periph_srst}, 32'h1);
    rd(12'h000, v); chk("R9 bit3 not stored", v, C);
    chk("R9 strobe ended", {30'h0, periph_srst}, 32'h0);
    wr(12'h000, C | 32'h1000, 4'h0);
    chk("R9 strobe 1", {30'h0, periph_srst}, 32'h2);
    rd(12'h000, v); chk("R9 bit12 not stored", v, C);

    finish_run();
  end
endmodule